// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst access. When either of two address strobes is sampled high, it captures the full incoming address. The upper bits are held unchanged for the rest of the burst. The low bits become the starting beat position. Each clock edge that samples the advance input high then moves the low bits to the next beat position. The order of those positions depends on a mode input, and the sequence wraps to the start position after the last beat.

Two orderings are available. Linear ordering adds the beat index to the start position, modulo the burst length. Interleaved ordering XORs the start position with the beat index. The burst length is two to the power of the low-field width, so the default 2-bit field gives four beats. The output address is registered and changes on the clock edge that samples a strobe or an advance.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is sampled high on a rising edge, `addr_out` becomes all zeros on that edge.
- R2: When `strobe_a` is high at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge, from that edge onward.
- R3: When `strobe_b` is high at a rising edge, it loads `addr_in` exactly as `strobe_a` does. Either strobe alone is sufficient.
- R4: With `order_mode` = 0 (linear), each advance sets the low field of `addr_out` to (start + k) mod 4. Here start is the captured low field and k is the number of advances since the strobe. Example from start 2: 2, 3, 0, 1.
- R5: With `order_mode` = 1 (interleaved), each advance sets the low field to start XOR k. Examples: from start 1 the sequence is 1, 0, 3, 2; from start 2 it is 2, 3, 0, 1.
- R6: After four advances the low field returns to the start position and the sequence continues without stopping.
- R7: An edge with no strobe and no advance leaves `addr_out` unchanged.
- R8: A strobe at the same edge as an advance takes priority. `addr_out` loads `addr_in` and the beat index restarts at zero.
- R9: Without a strobe, the upper field (`addr_out[ADDR_W-1:2]`) never changes, even across advances and wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_a | input | 1 | First address strobe; loads a new start address |
| strobe_b | input | 1 | Second address strobe; same effect as `strobe_a` |
| advance | input | 1 | Step to the next beat position |
| order_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | Address captured on a strobe |
| addr_out | output | ADDR_W | Registered beat address: held upper field plus sequenced low field |

## Verification
The directed cases are built around wrap-around and strobe priority. The bench drives four advances and expects the start position to come back. A counter that saturated, or that restarted from zero instead of from the start, would miss this on the fifth beat. A strobe arriving together with an advance must reload the address and restart the beat index, so a design that let advance win would show a stepped position in place of the new address. Interleaved bursts from odd start positions are where a linear adder produces 2, 3 where 0, 3 is expected. Randomized cycles mix in idle edges to catch an output that drifts while advance is low. They also mix in long bursts to catch upper bits that get disturbed by a carry out of the low field.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_inc
);
  assign beat_inc = beat_q + BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       beat_q <= '0;
    else if (load) beat_q <= '0;
    else if (step) beat_q <= beat_inc;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            mode,
  output logic [BEAT_W-1:0] pos
);
  always_comb begin
    unique case (mode)
      ORDER_INTERLEAVE: pos = start ^ beat;
      default:          pos = start + beat;
    endcase
  end
endmodule

// File: rtl/burst_addr_hold.sv
module burst_addr_hold #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic [BEAT_W-1:0]        start_q,
  output logic [ADDR_W-BEAT_W-1:0] upper_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      upper_q <= '0;
    end else if (load) begin
      start_q <= addr_in[BEAT_W-1:0];
      upper_q <= addr_in[ADDR_W-1:BEAT_W];
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              advance,
  input  logic              order_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic               load;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  beat_inc;
  logic [BEAT_W-1:0]  start_q;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  next_pos;
  logic [BEAT_W-1:0]  low_q;
  order_e             mode;

  assign load = strobe_a | strobe_b;
  assign mode = order_e'(order_mode);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk(clk), .rst(rst), .load(load), .step(advance),
    .beat_q(beat_q), .beat_inc(beat_inc)
  );

  burst_addr_hold #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_hold (
    .clk(clk), .rst(rst), .load(load), .addr_in(addr_in),
    .start_q(start_q), .upper_q(upper_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start(start_q), .beat(beat_inc), .mode(mode), .pos(next_pos)
  );

  always_ff @(posedge clk) begin
    if (rst)          low_q <= '0;
    else if (load)    low_q <= addr_in[BEAT_W-1:0];
    else if (advance) low_q <= next_pos;
  end

  assign addr_out = {upper_q, low_q};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_a,
  input logic              strobe_b,
  input logic              advance,
  input logic              order_mode,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out
);
  // R2 R3 R8
  strobe_load_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_a || strobe_b) |=> addr_out == $past(addr_in));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_a && !strobe_b && !advance) |=> $stable(addr_out));

  // R9
  upper_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_a && !strobe_b) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !strobe_a && !strobe_b && !order_mode)
      |=> addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
  .advance(advance), .order_mode(order_mode), .addr_in(addr_in),
  .addr_out(addr_out)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int ADDR_W = 17;
  localparam int BEAT_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_a = 1'b0, strobe_b = 1'b0, advance = 1'b0, order_mode = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] addr_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [1:0]        m_start, m_beat, m_low;
  logic [ADDR_W-3:0] m_upper;
  logic              m_mode;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
    .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .advance(advance), .order_mode(order_mode), .addr_in(addr_in),
    .addr_out(addr_out)
  );

  function automatic logic [1:0] beat_pos(input logic [1:0] s, input logic [1:0] k,
                                          input logic mode);
    return mode ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    checks++;
    if (addr_out !== exp) begin
      failures++;
      $display("FAIL %s addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  // Drive at a falling edge, clock once, update model, check at the next falling edge.
  task automatic cyc(input logic sa, input logic sb, input logic adv,
                     input logic mode, input logic [ADDR_W-1:0] a);
    string req;
    strobe_a = sa; strobe_b = sb; advance = adv; order_mode = mode; addr_in = a;
    @(posedge clk);
    if (sa || sb) begin
      m_start = a[1:0]; m_upper = a[ADDR_W-1:2]; m_beat = 2'd0; m_low = a[1:0];
      m_mode = mode;
      req = adv ? "R8" : (sa ? "R2" : "R3");
    end else if (adv) begin
      m_beat = m_beat + 2'd1;
      m_low = beat_pos(m_start, m_beat, mode);
      req = mode ? "R5/R9" : "R4/R9";
    end else begin
      req = "R7";
    end
    @(negedge clk);
    check(req, {m_upper, m_low});
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_start = '0; m_beat = '0; m_low = '0; m_upper = '0; m_mode = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1", '0);                       // R1 reset state
    rst = 1'b0;

    // R4: linear from start 2 -> 2,3,0,1 then R6 wrap back to 2
    cyc(1, 0, 0, 0, 17'h1A5A6);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, '0);
    cyc(0, 0, 1, 0, '0);
    checks++; if (addr_out[1:0] !== 2'd2) begin failures++;
      $display("FAIL R6 low=%0d expected=2", addr_out[1:0]); end

    // R5: interleaved from start 1 -> 1,0,3,2 via strobe_b (R3)
    cyc(0, 1, 0, 1, 17'h0F3C1);
    cyc(0, 0, 1, 1, '0);
    checks++; if (addr_out[1:0] !== 2'd0) begin failures++;
      $display("FAIL R5 low=%0d expected=0", addr_out[1:0]); end
    cyc(0, 0, 1, 1, '0);
    checks++; if (addr_out[1:0] !== 2'd3) begin failures++;
      $display("FAIL R5 low=%0d expected=3", addr_out[1:0]); end
    cyc(0, 0, 0, 1, 17'h1FFFF);            // R7 idle
    cyc(0, 0, 1, 1, '0);
    cyc(0, 0, 1, 1, '0);                   // R6 wrap in interleaved mode
    checks++; if (addr_out[1:0] !== 2'd1) begin failures++;
      $display("FAIL R6 low=%0d expected=1", addr_out[1:0]); end

    // R8: strobe with advance on the same edge
    cyc(1, 1, 1, 0, 17'h00003);
    cyc(0, 0, 1, 0, '0);
    checks++; if (addr_out[1:0] !== 2'd0) begin failures++;
      $display("FAIL R8 low=%0d expected=0", addr_out[1:0]); end

    // Random mix; mode changes only on strobe cycles
    for (int n = 0; n < 3000; n++) begin
      logic sa, sb, adv, md;
      int r;
      r = int'($urandom_range(0, 99));
      sa = (r < 6); sb = (r >= 6 && r < 10);
      adv = ($urandom_range(0, 99) < 60);
      md = (sa || sb) ? 1'($urandom_range(0, 1)) : m_mode;
      cyc(sa, sb, adv, md, ADDR_W'($urandom));
    end

    // R1 again: reset mid-burst
    strobe_a = 0; strobe_b = 0; advance = 1; rst = 1;
    @(negedge clk);
    check("R1", '0);
    rst = 0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule